// File: doc/BRIEF.md
# CAN Error and Status Capture Word

This block sits beside a CAN protocol engine and folds its error and status signals into one 16-bit read-only word. The engine raises single-cycle strobes when it detects an error. The block keeps each of these as a sticky flag until software reads the word. The engine also supplies its transmit and receive error counters and its bus activity levels. From these the block derives the warning flags and the fault confinement state, and it refreshes them on every clock.

A read strobe marks the cycle in which software samples the word. The value seen in that cycle is the content held before the read. On the following edge the sticky fields clear, unless a new error arrives in the same cycle. Bit-error capture is suppressed during the arbitration field, the ACK slot and a passive error flag, because a mismatch there is part of normal operation. A soft reset clears the whole word. If the node is still bus-off, the bus-off state reappears one edge after the soft reset is released.

Top module: `can_err_status`

## Requirements
- R1: The word is laid out as follows: bit-error code at [15:14], acknowledge error at 13, CRC error at 12, form error at 11, stuff error at 10, transmit warning at 9, receive warning at 8, bus idle at 7, direction at 6 and fault state at [5:4]. Bits [3:0] always read 0. All fields are registered and change one edge after their inputs.
- R2: The bit-error field is 2'b01 when a bit driven dominant is sampled recessive, and 2'b10 when a bit driven recessive is sampled dominant. It never reads 2'b11. If both strobes come in one cycle, 2'b01 wins. A nonzero code holds until a read, and later errors do not overwrite it.
- R3: While the arbitration field, the ACK slot or a passive error flag is flagged, bit-error strobes leave the bit-error field unchanged.
- R4: The acknowledge, CRC, form and stuff error bits each set on the edge where their strobe is high, and they stay set while no read occurs.
- R5: A read strobe returns the held value in its own cycle. On the next edge it clears every sticky field (bits [15:10]). A strobe that coincides with the read leaves its field set, or for the bit-error field, set to the new code.
- R6: The transmit warning is 1 when the transmit counter is 96 or more, and 0 otherwise. The receive warning follows the same rule on the receive counter.
- R7: The bus idle bit follows the idle input and the direction bit follows the transmit input (1 = transmitting). Reads do not affect either bit.
- R8: The fault state is 2'b10 when the transmit counter is 256 or more or the bus-off input is high. Otherwise it is 2'b01 when either counter is 128 or more, and 2'b00 in all other cases.
- R9: A soft reset clears the whole word on the next edge, fault state included. If the node is bus-off, the first edge with the soft reset low shows 2'b10 again.
- R10: While rst_n is low at an edge, the word becomes all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of the whole word |
| rd_stb | input | 1 | Software read of the word in this cycle |
| biterr_dom | input | 1 | Bit driven dominant, sampled recessive |
| biterr_rec | input | 1 | Bit driven recessive, sampled dominant |
| ack_err | input | 1 | Acknowledge error strobe |
| crc_err | input | 1 | CRC error strobe |
| form_err | input | 1 | Form error strobe |
| stuff_err | input | 1 | Stuff error strobe |
| in_arb | input | 1 | Arbitration field being sent |
| in_ack_slot | input | 1 | ACK slot being sent |
| passive_flag | input | 1 | Node sending a passive error flag |
| tx_cnt | input | 9 | Transmit error counter |
| rx_cnt | input | 9 | Receive error counter |
| bus_idle | input | 1 | Bus idle level |
| is_tx | input | 1 | Node transmitting (1) or receiving (0) |
| bus_off | input | 1 | Bus-off indication from the engine |
| status | output | 16 | Status word |

## Verification
The hardest situations to reach are those where a clearing read coincides with an error strobe, and where a soft reset arrives while the node is bus-off. In both, the visible result depends on the exact edge on which two inputs meet. Directed sequences place a read on the same cycle as an acknowledge, CRC or bit-error strobe, and they hold the bus-off input high across a soft-reset pulse while sampling the word on the edges before, during and after it. A long stretch of random strobes, masks, reads and counter values then runs against a behavioural model that is compared on every clock.

// File: rtl/can_err_pkg.sv
// Package: shared encodings and field positions for the CAN status word.
// Assumes a 16-bit word with the sticky fields in the upper six bits.
package can_err_pkg;

    localparam int WORD_W = 16;

    // Bit positions of the word; software decodes these.
    localparam int POS_BIT_HI = 15;
    localparam int POS_BIT_LO = 14;
    localparam int POS_ACK    = 13;
    localparam int POS_CRC    = 12;
    localparam int POS_FORM   = 11;
    localparam int POS_STUFF  = 10;
    localparam int POS_TXW    = 9;
    localparam int POS_RXW    = 8;
    localparam int POS_IDLE   = 7;
    localparam int POS_DIR    = 6;
    localparam int POS_FCS_HI = 5;
    localparam int POS_FCS_LO = 4;

    localparam int NUM_STICKY = 4;

    typedef enum logic [1:0] {
        BE_NONE     = 2'b00,
        BE_DOM_LOST = 2'b01,
        BE_REC_LOST = 2'b10
    } biterr_e;

    typedef enum logic [1:0] {
        FS_ACTIVE  = 2'b00,
        FS_PASSIVE = 2'b01,
        FS_BUSOFF  = 2'b10
    } fault_e;

    typedef struct packed {
        logic   tx_warn;
        logic   rx_warn;
        logic   idle;
        logic   dir_tx;
        fault_e fault;
    } level_t;

endpackage

// File: rtl/ces_sticky_flags.sv
// Module: bank of sticky error flags, set by strobes and cleared by a read.
// Assumes strobes last one cycle; a strobe that coincides with a read wins.
module ces_sticky_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         rd,
    input  logic [N-1:0] set,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Per-flag sticky register with clear-on-read.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                flags[i] <= 1'b0;
            end else if (set[i]) begin
                flags[i] <= 1'b1;
            end else if (rd) begin
                flags[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ces_biterr_capture.sv
// Module: captures the first unmasked transmit bit error as a 2-bit code.
// Assumes the mask is high during arbitration, the ACK slot and passive flags.
module ces_biterr_capture
    import can_err_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clr,
    input  logic    rd,
    input  logic    dom_lost,
    input  logic    rec_lost,
    input  logic    mask,
    output biterr_e code
);
    biterr_e ev;

    // Encode this cycle's event; dominant-lost has priority.
    always_comb begin
        ev = BE_NONE;
        if (!mask) begin
            if (dom_lost)      ev = BE_DOM_LOST;
            else if (rec_lost) ev = BE_REC_LOST;
        end
    end

    // Hold the first code; a read reloads with this cycle's event.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            code <= BE_NONE;
        end else if (rd || code == BE_NONE) begin
            code <= ev;
        end
    end
endmodule

// File: rtl/ces_level_status.sv
// Module: registers the level fields (warnings, idle, direction, fault state).
// Assumes counters saturate within CNT_W bits; reads have no effect here.
module ces_level_status
    import can_err_pkg::*;
#(
    parameter int CNT_W    = 9,
    parameter int WARN_LIM = 96,
    parameter int PASS_LIM = 128,
    parameter int OFF_LIM  = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic             bus_idle,
    input  logic             is_tx,
    input  logic             bus_off,
    output level_t           lvl
);
    localparam logic [CNT_W-1:0] WARN_C = CNT_W'(WARN_LIM);
    localparam logic [CNT_W-1:0] PASS_C = CNT_W'(PASS_LIM);
    localparam logic [CNT_W-1:0] OFF_C  = CNT_W'(OFF_LIM);

    level_t nxt;

    // Derive the next level fields from the counters and bus levels.
    always_comb begin
        nxt.tx_warn = (tx_cnt >= WARN_C);
        nxt.rx_warn = (rx_cnt >= WARN_C);
        nxt.idle    = bus_idle;
        nxt.dir_tx  = is_tx;
        if (bus_off || tx_cnt >= OFF_C) begin
            nxt.fault = FS_BUSOFF;
        end else if (tx_cnt >= PASS_C || rx_cnt >= PASS_C) begin
            nxt.fault = FS_PASSIVE;
        end else begin
            nxt.fault = FS_ACTIVE;
        end
    end

    // Refresh every cycle; a soft reset forces zero for one edge.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            lvl <= '0;
        end else begin
            lvl <= nxt;
        end
    end
endmodule

// File: rtl/can_err_status.sv
// Module: top of the CAN error/status capture word.
// Combines sticky error flags, the bit-error code and the level fields into a
// 16-bit word. Assumes strobes are synchronous to clk and one cycle wide.
module can_err_status
    import can_err_pkg::*;
#(
    parameter int CNT_W    = 9,
    parameter int WARN_LIM = 96,
    parameter int PASS_LIM = 128,
    parameter int OFF_LIM  = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             rd_stb,
    input  logic             biterr_dom,
    input  logic             biterr_rec,
    input  logic             ack_err,
    input  logic             crc_err,
    input  logic             form_err,
    input  logic             stuff_err,
    input  logic             in_arb,
    input  logic             in_ack_slot,
    input  logic             passive_flag,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic             bus_idle,
    input  logic             is_tx,
    input  logic             bus_off,
    output logic [WORD_W-1:0] status
);
    logic [NUM_STICKY-1:0] sticky;
    biterr_e               bcode;
    level_t                lvl;
    logic                  bmask;

    // Bit errors are expected during arbitration, ACK slot and passive flag.
    assign bmask = in_arb | in_ack_slot | passive_flag;

    ces_sticky_flags #(.N(NUM_STICKY)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (soft_rst),
        .rd    (rd_stb),
        .set   ({ack_err, crc_err, form_err, stuff_err}),
        .flags (sticky)
    );

    ces_biterr_capture u_bit (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (soft_rst),
        .rd       (rd_stb),
        .dom_lost (biterr_dom),
        .rec_lost (biterr_rec),
        .mask     (bmask),
        .code     (bcode)
    );

    ces_level_status #(
        .CNT_W    (CNT_W),
        .WARN_LIM (WARN_LIM),
        .PASS_LIM (PASS_LIM),
        .OFF_LIM  (OFF_LIM)
    ) u_lvl (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (soft_rst),
        .tx_cnt   (tx_cnt),
        .rx_cnt   (rx_cnt),
        .bus_idle (bus_idle),
        .is_tx    (is_tx),
        .bus_off  (bus_off),
        .lvl      (lvl)
    );

    // Assemble the word from the registered fields.
    always_comb begin
        status = '0;
        status[POS_BIT_HI:POS_BIT_LO] = bcode;
        status[POS_ACK]   = sticky[3];
        status[POS_CRC]   = sticky[2];
        status[POS_FORM]  = sticky[1];
        status[POS_STUFF] = sticky[0];
        status[POS_TXW]   = lvl.tx_warn;
        status[POS_RXW]   = lvl.rx_warn;
        status[POS_IDLE]  = lvl.idle;
        status[POS_DIR]   = lvl.dir_tx;
        status[POS_FCS_HI:POS_FCS_LO] = lvl.fault;
    end
endmodule

// File: rtl/can_err_status_checker.sv
// Module: temporal checks on the status word, bound to can_err_status.
// Assumes the default field layout of the package.
module can_err_status_checker #(
    parameter int CNT_W    = 9,
    parameter int WARN_LIM = 96
) (
    input logic             clk,
    input logic             rst_n,
    input logic             soft_rst,
    input logic             rd_stb,
    input logic             ack_err,
    input logic             biterr_dom,
    input logic             biterr_rec,
    input logic             in_arb,
    input logic             in_ack_slot,
    input logic             passive_flag,
    input logic [CNT_W-1:0] tx_cnt,
    input logic             bus_off,
    input logic [15:0]      status
);
    // R1: low nibble always reads zero
    p_low_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        status[3:0] == 4'h0);

    // R2: reserved code never appears
    p_no_code3_r2: assert property (@(posedge clk) disable iff (!rst_n)
        status[15:14] != 2'b11);

    // R3: masked phases leave the bit-error code unchanged
    p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_arb || in_ack_slot || passive_flag) && !rd_stb && !soft_rst
        |=> $stable(status[15:14]));

    // R4: acknowledge flag holds without a read
    p_sticky_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        status[13] && !rd_stb && !soft_rst |=> status[13]);

    // R5: read without a new strobe clears acknowledge flag
    p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && !ack_err && !soft_rst |=> !status[13]);

    // R5: read with no unmasked bit error clears the code
    p_read_clear_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && !soft_rst && !biterr_dom && !biterr_rec |=> status[15:14] == 2'b00);

    // R6: transmit warning tracks the threshold
    p_txwarn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst && tx_cnt >= CNT_W'(WARN_LIM) |=> status[9]);

    // R8: bus-off input forces the bus-off state
    p_busoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst && bus_off |=> status[5:4] == 2'b10);

    // R9: soft reset clears the whole word
    p_soft_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> status == 16'h0000);
endmodule

bind can_err_status can_err_status_checker #(
    .CNT_W    (CNT_W),
    .WARN_LIM (WARN_LIM)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .rd_stb       (rd_stb),
    .ack_err      (ack_err),
    .biterr_dom   (biterr_dom),
    .biterr_rec   (biterr_rec),
    .in_arb       (in_arb),
    .in_ack_slot  (in_ack_slot),
    .passive_flag (passive_flag),
    .tx_cnt       (tx_cnt),
    .bus_off      (bus_off),
    .status       (status)
);

// File: tb/can_err_status_bench.sv
// Bench: behavioural reference model compared on every clock plus directed checks.
module can_err_status_bench;
    logic       clk = 1'b0;
    logic       rst_n, soft_rst, rd_stb;
    logic       biterr_dom, biterr_rec, ack_err, crc_err, form_err, stuff_err;
    logic       in_arb, in_ack_slot, passive_flag;
    logic [8:0] tx_cnt, rx_cnt;
    logic       bus_idle, is_tx, bus_off;
    logic [15:0] status;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model state
    int m_bit, m_ack, m_crc, m_form, m_stuff;
    int m_txw, m_rxw, m_idle, m_dir, m_fcs;

    always #10 clk = ~clk;  // 50 MHz

    can_err_status u_can_err_status (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rd_stb(rd_stb),
        .biterr_dom(biterr_dom), .biterr_rec(biterr_rec), .ack_err(ack_err),
        .crc_err(crc_err), .form_err(form_err), .stuff_err(stuff_err),
        .in_arb(in_arb), .in_ack_slot(in_ack_slot), .passive_flag(passive_flag),
        .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .bus_idle(bus_idle), .is_tx(is_tx),
        .bus_off(bus_off), .status(status)
    );

    // Reference model update on each rising edge.
    always @(posedge clk) begin
        int ev;
        if (!rst_n || soft_rst) begin
            m_bit = 0; m_ack = 0; m_crc = 0; m_form = 0; m_stuff = 0;
            m_txw = 0; m_rxw = 0; m_idle = 0; m_dir = 0; m_fcs = 0;
        end else begin
            ev = 0;
            if (!(in_arb || in_ack_slot || passive_flag))
                ev = biterr_dom ? 1 : (biterr_rec ? 2 : 0);
            if (rd_stb) m_bit = ev;
            else if (m_bit == 0) m_bit = ev;
            m_ack   = (ack_err   || (m_ack   != 0 && !rd_stb)) ? 1 : 0;
            m_crc   = (crc_err   || (m_crc   != 0 && !rd_stb)) ? 1 : 0;
            m_form  = (form_err  || (m_form  != 0 && !rd_stb)) ? 1 : 0;
            m_stuff = (stuff_err || (m_stuff != 0 && !rd_stb)) ? 1 : 0;
            m_txw  = (int'(tx_cnt) >= 96) ? 1 : 0;
            m_rxw  = (int'(rx_cnt) >= 96) ? 1 : 0;
            m_idle = bus_idle ? 1 : 0;
            m_dir  = is_tx ? 1 : 0;
            if (bus_off || int'(tx_cnt) > 255) m_fcs = 2;
            else if (int'(tx_cnt) >= 128 || int'(rx_cnt) >= 128) m_fcs = 1;
            else m_fcs = 0;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison of every field against the model.
    always @(negedge clk) begin
        if (!done) begin
            chk("R2/R5 biterr", int'(status[15:14]), m_bit);
            chk("R4/R5 ack",    int'(status[13]), m_ack);
            chk("R4/R5 crc",    int'(status[12]), m_crc);
            chk("R4/R5 form",   int'(status[11]), m_form);
            chk("R4/R5 stuff",  int'(status[10]), m_stuff);
            chk("R6 txwarn",    int'(status[9]), m_txw);
            chk("R6 rxwarn",    int'(status[8]), m_rxw);
            chk("R7 idle",      int'(status[7]), m_idle);
            chk("R7 dir",       int'(status[6]), m_dir);
            chk("R8 fcs",       int'(status[5:4]), m_fcs);
            chk("R1 low",       int'(status[3:0]), 0);
        end
    end

    task automatic quiet();
        soft_rst = 0; rd_stb = 0; biterr_dom = 0; biterr_rec = 0;
        ack_err = 0; crc_err = 0; form_err = 0; stuff_err = 0;
        in_arb = 0; in_ack_slot = 0; passive_flag = 0;
    endtask

    // Advance one clock; returns at the following falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; quiet(); tx_cnt = 0; rx_cnt = 0;
        bus_idle = 1; is_tx = 1; bus_off = 0;
        @(negedge clk);
        tick(); tick();
        chk("R10 reset word", int'(status), 0);
        rst_n = 1;
        tick();
        chk("R1 idle after reset", int'(status), 16'h0080 | 16'h0040);

        // R4: sticky set and hold
        ack_err = 1; tick(); ack_err = 0;
        chk("R4 ack set", int'(status[13]), 1);
        tick(); tick();
        chk("R4 ack held", int'(status[13]), 1);
        // R5: read returns old value, then clears
        rd_stb = 1; #1;
        chk("R5 read sees set", int'(status[13]), 1);
        tick(); rd_stb = 0;
        chk("R5 cleared", int'(status[13]), 0);
        // R5: strobe coincident with read keeps flag
        crc_err = 1; tick(); crc_err = 0;
        rd_stb = 1; crc_err = 1; tick(); rd_stb = 0; crc_err = 0;
        chk("R5 coincident keep", int'(status[12]), 1);
        rd_stb = 1; tick(); rd_stb = 0;

        // R2: encodings, priority, hold of first code
        biterr_dom = 1; tick(); biterr_dom = 0;
        chk("R2 dom lost 01", int'(status[15:14]), 1);
        biterr_rec = 1; tick(); biterr_rec = 0;
        chk("R2 first code holds", int'(status[15:14]), 1);
        rd_stb = 1; tick(); rd_stb = 0;
        chk("R5 biterr cleared", int'(status[15:14]), 0);
        biterr_rec = 1; tick(); biterr_rec = 0;
        chk("R2 rec lost 10", int'(status[15:14]), 2);
        rd_stb = 1; biterr_dom = 1; biterr_rec = 1; tick();
        rd_stb = 0; biterr_dom = 0; biterr_rec = 0;
        chk("R2 both -> 01 with read", int'(status[15:14]), 1);
        rd_stb = 1; tick(); rd_stb = 0;

        // R3: masking phases
        in_arb = 1; biterr_dom = 1; tick(); quiet();
        chk("R3 arb masked", int'(status[15:14]), 0);
        in_ack_slot = 1; biterr_rec = 1; tick(); quiet();
        chk("R3 ack slot masked", int'(status[15:14]), 0);
        passive_flag = 1; biterr_rec = 1; tick(); quiet();
        chk("R3 passive flag masked", int'(status[15:14]), 0);

        // R6/R8: threshold sweep
        tx_cnt = 95;  tick(); chk("R6 tx 95", int'(status[9]), 0);
        tx_cnt = 96;  tick(); chk("R6 tx 96", int'(status[9]), 1);
        tx_cnt = 127; tick(); chk("R8 tx 127 active", int'(status[5:4]), 0);
        tx_cnt = 128; tick(); chk("R8 tx 128 passive", int'(status[5:4]), 1);
        tx_cnt = 255; tick(); chk("R8 tx 255 passive", int'(status[5:4]), 1);
        tx_cnt = 256; tick(); chk("R8 tx 256 busoff", int'(status[5:4]), 2);
        tx_cnt = 0; rx_cnt = 96; tick(); chk("R6 rx 96", int'(status[8]), 1);
        rx_cnt = 128; tick(); chk("R8 rx 128 passive", int'(status[5:4]), 1);
        rx_cnt = 0;

        // R7: levels unaffected by reads
        bus_idle = 0; is_tx = 0; rd_stb = 1; tick(); rd_stb = 0;
        chk("R7 idle 0", int'(status[7]), 0);
        chk("R7 dir rx", int'(status[6]), 0);

        // R9: soft reset while bus-off
        bus_off = 1; ack_err = 1; tick(); ack_err = 0;
        chk("R8 busoff input", int'(status[5:4]), 2);
        soft_rst = 1; tick(); soft_rst = 0;
        chk("R9 soft clear", int'(status), 0);
        tick();
        chk("R9 busoff returns", int'(status[5:4]), 2);
        bus_off = 0; tick();

        // Random phase against the model
        for (int i = 0; i < 2000; i++) begin
            rd_stb       = ($urandom % 5) == 0;
            biterr_dom   = ($urandom % 6) == 0;
            biterr_rec   = ($urandom % 6) == 0;
            ack_err      = ($urandom % 7) == 0;
            crc_err      = ($urandom % 7) == 0;
            form_err     = ($urandom % 7) == 0;
            stuff_err    = ($urandom % 7) == 0;
            in_arb       = ($urandom % 4) == 0;
            in_ack_slot  = ($urandom % 8) == 0;
            passive_flag = ($urandom % 8) == 0;
            soft_rst     = ($urandom % 50) == 0;
            bus_off      = ($urandom % 20) == 0;
            bus_idle     = 1'($urandom);
            is_tx        = 1'($urandom);
            tx_cnt       = 9'($urandom % 300);
            rx_cnt       = 9'($urandom % 200);
            if (i % 400 == 399) rst_n = 0; else rst_n = 1;
            tick();
        end
        quiet(); rst_n = 1; tick();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule